// File: doc/BRIEF.md
# Exact Quotient Unit for Odd Word Divisors

This block divides a multi-word unsigned integer by an odd single-word divisor, on the condition that the division leaves no remainder. It does not use long division from the most significant end. It works upward from the least significant word. Each step multiplies the current low word of the running value by the modular inverse of the divisor, which gives the next quotient word directly. It then subtracts that word times the divisor and drops the low word, which is now zero. No quotient estimates and no correction steps are needed.

The caller supplies the dividend, the divisor and the negated word inverse of the divisor. The negated inverse is the value that, multiplied by the divisor, gives minus one modulo two to the word width. The caller raises a one-cycle start. One step is taken per clock, so a full result takes one cycle per dividend word. The end is marked by a one-cycle done pulse.

A debug flag reports a violated precondition. This happens when the divisor does not divide the dividend, or when the supplied inverse does not belong to the divisor.

Top module: `exdiv_core`

## Requirements
- R1: While reset is held (active-low `rst_n`), `busy`, `done`, `quotient` and `residue_err` are all zero.
- R2: A `start` seen at a clock edge while idle makes `busy` high from that edge for exactly NUM_WORDS cycles. `done` is high for exactly one cycle, the cycle in which `busy` has just fallen.
- R3: When `divisor` is odd, `neg_inv` times `divisor` is minus one modulo 2^WORD_W, and `divisor` divides `dividend`, then the `quotient` present with `done` equals dividend/divisor. This includes divisor 1, divisor 2^WORD_W-1, a zero dividend and the largest multiple that fits.
- R4: While idle, `quotient` and `residue_err` keep their last values until the next accepted `start`.
- R5: A `start` raised while `busy` is high is ignored. The run in progress keeps its timing and its operands.
- R6: With a correct inverse, `residue_err` is low at `done` when the divisor divides the dividend and high when it does not.
- R7: With an odd dividend and an inverse that does not match the divisor, `residue_err` is high at `done`.
- R8: An accepted `start` clears `residue_err`, so it reads low in the first busy cycle.
- R9: A `start` seen at the edge that ends a run, while `done` is high, is accepted and begins the next run at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division; taken only when idle |
| dividend | input | WORD_W*NUM_WORDS | Integer to divide, captured at start |
| divisor | input | WORD_W | Odd divisor, captured at start |
| neg_inv | input | WORD_W | Minus the inverse of the divisor modulo 2^WORD_W, captured at start |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: the result is ready |
| quotient | output | WORD_W*NUM_WORDS | Result, valid with done and held while idle |
| residue_err | output | 1 | Precondition violation seen in the last run |

## Verification
The bench builds the block with its default 32-bit words and four-word dividends. Four steps per run keep every cycle of a run visible. At this width a random 96-bit quotient times a random odd divisor fills all four dividend words, and the largest multiple below 2^128 tests the top word at its limit. The behavioural model takes its quotient and error expectations from plain 128-bit division and remainder. This covers restart in the done cycle, starts made during a run, and both ways the precondition can be broken.

// File: rtl/exdiv_pkg.sv
package exdiv_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    function automatic int unsigned cnt_bits(input int unsigned steps);
        return (steps > 1) ? $clog2(steps) : 1;
    endfunction

endpackage

// File: rtl/exdiv_lomul.sv
module exdiv_lomul #(
    parameter int WORD_W = 32
) (
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    output logic [WORD_W-1:0] lo_o
);
    // low word of the product only; the high half never matters here
    assign lo_o = a_i * b_i;
endmodule

// File: rtl/exdiv_step.sv
module exdiv_step #(
    parameter int WORD_W = 32,
    parameter int REM_W  = 161
) (
    input  logic [REM_W-1:0]  rem_i,
    input  logic [WORD_W-1:0] dvs_i,
    input  logic [WORD_W-1:0] inv_i,
    output logic [WORD_W-1:0] qword_o,
    output logic [REM_W-1:0]  rem_o,
    output logic              slip_o
);
    localparam int PROD_W = 2 * WORD_W;

    logic [PROD_W-1:0] prod;
    logic [REM_W-1:0]  diff;

    exdiv_lomul #(.WORD_W(WORD_W)) qmul_i (
        .a_i (rem_i[WORD_W-1:0]),
        .b_i (inv_i),
        .lo_o(qword_o)
    );

    always_comb begin
        prod   = {{WORD_W{1'b0}}, qword_o} * {{WORD_W{1'b0}}, dvs_i};
        diff   = rem_i - {{(REM_W-PROD_W){1'b0}}, prod};
        // a correct inverse always clears the low word
        slip_o = |diff[WORD_W-1:0];
        // signed shift keeps a negative residue visible for the final test
        rem_o  = {{WORD_W{diff[REM_W-1]}}, diff[REM_W-1:WORD_W]};
    end
endmodule

// File: rtl/exdiv_core.sv
module exdiv_core #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [WORD_W*NUM_WORDS-1:0] dividend,
    input  logic [WORD_W-1:0]           divisor,
    input  logic [WORD_W-1:0]           neg_inv,
    output logic                        busy,
    output logic                        done,
    output logic [WORD_W*NUM_WORDS-1:0] quotient,
    output logic                        residue_err
);
    import exdiv_pkg::*;

    localparam int N_W   = WORD_W * NUM_WORDS;
    localparam int REM_W = N_W + WORD_W + 1;
    localparam int CNT_W = cnt_bits(NUM_WORDS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WORDS - 1);

    typedef struct packed {
        phase_e             phase;
        logic               done;
        logic [CNT_W-1:0]   cnt;
        logic [REM_W-1:0]   rem;
        logic [N_W-1:0]     quot;
        logic [WORD_W-1:0]  inv;
        logic [WORD_W-1:0]  dvs;
        logic               err;
    } state_t;

    state_t st_d, st_q;

    logic [WORD_W-1:0] qword;
    logic [REM_W-1:0]  rem_next;
    logic              slip;
    logic [N_W-1:0]    quot_shift;

    exdiv_step #(.WORD_W(WORD_W), .REM_W(REM_W)) step_i (
        .rem_i  (st_q.rem),
        .dvs_i  (st_q.dvs),
        .inv_i  (st_q.inv),
        .qword_o(qword),
        .rem_o  (rem_next),
        .slip_o (slip)
    );

    // new words enter at the top and move down, so the first word lands lowest
    if (NUM_WORDS == 1) begin : g_single
        assign quot_shift = qword;
    end else begin : g_multi
        assign quot_shift = {qword, st_q.quot[N_W-1:WORD_W]};
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.phase == PH_IDLE) begin
            if (start) begin
                st_d.phase = PH_RUN;
                st_d.cnt   = '0;
                st_d.rem   = {{(REM_W-N_W){1'b0}}, dividend};
                st_d.quot  = '0;
                st_d.inv   = -neg_inv;
                st_d.dvs   = divisor;
                st_d.err   = 1'b0;
            end
        end else begin
            st_d.quot = quot_shift;
            st_d.rem  = rem_next;
            st_d.err  = st_q.err | slip;
            if (st_q.cnt == LAST) begin
                st_d.phase = PH_IDLE;
                st_d.done  = 1'b1;
                // anything left after the last word means n was no multiple
                st_d.err   = st_q.err | slip | (|rem_next);
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy        = (st_q.phase == PH_RUN);
    assign done        = st_q.done;
    assign quotient    = st_q.quot;
    assign residue_err = st_q.err;

endmodule

// File: rtl/exdiv_checker.sv
module exdiv_checker #(
    parameter int WORD_W    = 32,
    parameter int NUM_WORDS = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        start,
    input logic                        busy,
    input logic                        done,
    input logic [WORD_W*NUM_WORDS-1:0] quotient,
    input logic                        residue_err
);
    int unsigned run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= 0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1;
        end else begin
            run_cnt <= 0;
        end
    end

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy);

    p_run_cont_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && run_cnt != NUM_WORDS - 1 |=> busy && !done);

    p_run_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy && run_cnt == NUM_WORDS - 1 |=> !busy && done);

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_after_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> $stable(quotient) && $stable(residue_err));

    p_ignore_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && run_cnt != NUM_WORDS - 1 |=> busy);

    p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !residue_err);

endmodule

bind exdiv_core exdiv_checker #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .quotient   (quotient),
    .residue_err(residue_err)
);

// File: tb/exdiv_core_tb.sv
module exdiv_core_tb_top;
    localparam int WW = 32;
    localparam int NW = 4;
    localparam int NB = WW * NW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NB-1:0] dividend = '0;
    logic [WW-1:0] divisor = 32'd1;
    logic [WW-1:0] neg_inv = '1;
    logic          busy, done, residue_err;
    logic [NB-1:0] quotient;

    int total = 0;
    int bad = 0;
    bit live = 1'b0;

    always #4 clk = ~clk;

    exdiv_core #(.WORD_W(WW), .NUM_WORDS(NW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
        .divisor(divisor), .neg_inv(neg_inv), .busy(busy), .done(done),
        .quotient(quotient), .residue_err(residue_err)
    );

    // behavioural model
    bit            m_busy = 0, m_done = 0, m_err = 0, p_err = 0;
    int            m_left = 0;
    logic [NB-1:0] m_q = '0, p_q = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy <= 0; m_done <= 0; m_err <= 0; m_q <= '0; m_left <= 0;
        end else begin
            m_done <= 0;
            if (!m_busy) begin
                if (start) begin
                    m_busy <= 1;
                    m_left <= NW;
                    p_q    <= dividend / {{(NB-WW){1'b0}}, divisor};
                    p_err  <= ((dividend % {{(NB-WW){1'b0}}, divisor}) != '0)
                              || ((divisor * (-neg_inv)) != 32'd1);
                end
            end else begin
                m_left <= m_left - 1;
                if (m_left == 1) begin
                    m_busy <= 0; m_done <= 1; m_q <= p_q; m_err <= p_err;
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [NB-1:0] act, input logic [NB-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            chk("R2 busy", NB'(busy), NB'(m_busy));
            chk("R2 done", NB'(done), NB'(m_done));
            if (m_busy && m_left == NW) chk("R8 residue_err cleared", NB'(residue_err), '0);
            if (!m_busy) begin
                chk(m_done ? "R6 residue_err at done" : "R4 residue_err held",
                    NB'(residue_err), NB'(m_err));
                if (!m_err) chk(m_done ? "R3 quotient" : "R4 quotient held", quotient, m_q);
            end
        end
    end

    function automatic logic [WW-1:0] minus_inv(input logic [WW-1:0] p);
        logic [WW-1:0] x = p;
        for (int i = 0; i < 5; i++) x = x * (32'd2 - p * x);
        return -x;
    endfunction

    function automatic logic [NB-1:0] rnd96();
        return {32'd0, $urandom, $urandom, $urandom};
    endfunction

    task automatic launch(input logic [NB-1:0] n, input logic [WW-1:0] p, input logic [WW-1:0] mu);
        @(negedge clk);
        dividend = n; divisor = p; neg_inv = mu; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (NW + 2) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [WW-1:0] p;
        logic [NB-1:0] q;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 busy", NB'(busy), '0);
        chk("R1 done", NB'(done), '0);
        chk("R1 quotient", quotient, '0);
        chk("R1 residue_err", NB'(residue_err), '0);
        rst_n = 1'b1;
        live = 1'b1;
        @(negedge clk);

        // R3 assorted exact divisions
        q = rnd96(); launch(q * 3, 32'd3, minus_inv(32'd3));
        q = rnd96(); launch(q, 32'd1, minus_inv(32'd1));
        q = rnd96(); launch(q * 32'hFFFF_FFFF, 32'hFFFF_FFFF, minus_inv(32'hFFFF_FFFF));
        launch('0, 32'd7, minus_inv(32'd7));
        p = 32'hDEAD_BEEF;
        q = {NB{1'b1}} / {{(NB-WW){1'b0}}, p};
        launch(q * p, p, minus_inv(p));
        for (int i = 0; i < 20; i++) begin
            p = $urandom | 32'd1;
            q = rnd96();
            launch(q * p, p, minus_inv(p));
        end

        // R6 not a multiple, then a clean run
        p = 32'd1001; q = rnd96();
        launch(q * p + 1, p, minus_inv(p));
        launch(q * p, p, minus_inv(p));
        // R7 mismatched inverse on an odd dividend
        p = 32'h0001_2345; q = rnd96() | 1;
        launch(q * p, p, minus_inv(p) + 32'd2);
        launch(q * p, p, minus_inv(p));

        // R5 start during a run with other operands
        p = 32'h0BAD_F00D | 1; q = rnd96();
        @(negedge clk);
        dividend = q * p; divisor = p; neg_inv = minus_inv(p); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        dividend = rnd96() + 5; divisor = 32'd9; neg_inv = 32'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (NW + 2) @(negedge clk);

        // R9 start held high: a new run begins in the done cycle
        p = 32'd65537; q = rnd96();
        @(negedge clk);
        dividend = q * p; divisor = p; neg_inv = minus_inv(p); start = 1'b1;
        repeat (2 * NW + 1) @(negedge clk);
        start = 1'b0;
        repeat (NW + 3) @(negedge clk);

        live = 1'b0;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule